// File: doc/BRIEF.md
# Column Binary Row-to-Column Transposer

This block turns a finished print line, held in a buffer organised by punch row, into a stream of column codes. The buffer holds 24 words of 36 bits. Each of the 12 punch rows takes two consecutive words: the first word covers columns 0 to 35 and the second covers columns 36 to 71. Inside a word, the most significant bit belongs to the lowest column. A start pulse makes the block walk the 72 columns in order. For each column it reads the 12 words that hold that column, one word per cycle, and builds a 12-bit code with one bit per punch row.

Each finished code is shown on a valid/ready output and held until the consumer takes it. The flag on column 71 marks the end of the line. After the last column is accepted, the block pulses `done` for one cycle. At that point `line_len` gives the index of the rightmost non-blank column plus one, so that a later stage can drop the trailing blanks. Mapping codes to characters is left to that later stage.

Top module: `ctp_transposer`

## Requirements
- R1: After reset, `col_valid`, `col_last`, `rd_en` and `done` are low and `line_len` is 0.
- R2: For each column c, the block issues exactly 12 reads with `rd_en` high, one per cycle, for rows 0 to 11 in that order. The address of each read is row*2 + c/36. `rd_data` is taken to return the addressed word one cycle after the read.
- R3: Bit r of `col_code` (0 is the LSB) equals bit 35 - (c mod 36) of the word read for row r. Row r is buffer row pair r, so code bits follow the buffer order: rows 9 down to 1, then 0, 11 and 12.
- R4: Columns 0 to 71 are presented in increasing order, each exactly once. `col_last` is high only with `col_valid`, and only on column 71.
- R5: While `col_valid` is high and `col_ready` is low, `col_valid`, `col_code` and `col_last` stay unchanged on the next cycle.
- R6: `done` goes high for exactly one cycle, in the cycle after column 71 is accepted. At that point `line_len` equals one plus the highest column whose code is non-zero, or 0 when every code is zero.
- R7: A `start` pulse while a line is in progress has no effect. The running line continues unchanged, and no further reads or columns follow its `done`.
- R8: No read is issued while a column is waiting to be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a line (ignored when busy) |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | 5 | Buffer word address |
| rd_data | input | 36 | Buffer word, one cycle after the read |
| col_code | output | 12 | Column code, bit r = punch row r |
| col_valid | output | 1 | Column code is presented |
| col_last | output | 1 | Presented column is column 71 |
| col_ready | input | 1 | Consumer accepts the column |
| done | output | 1 | One-cycle pulse after the line ends |
| line_len | output | 7 | Trimmed line length |

## Verification
The block is run on several buffer contents:
- An all-zero buffer checks the zero-length result.
- A single bit at column 0, row 0 and a single bit at column 71, row 11 pin down both ends of the bit ordering and of the length.
- A pair of bits at columns 35 and 36 separates the first half-word from the second.
- A diagonal in which column r carries only row r gives one-hot codes, so any swap of rows shows up.
- Random buffers, one of them with its right part cleared, test the gather and the trim together.

The consumer is driven as always ready, as randomly stalling and as alternating, which tests hold-until-accepted. Extra start pulses in the middle of a line check that a busy block ignores them.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

  localparam int unsigned CTP_ROWS   = 12;
  localparam int unsigned CTP_COLS   = 72;
  localparam int unsigned CTP_WORD_W = 36;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_PRESENT,
    ST_FINISH
  } ctp_state_e;

  // Buffer word that holds (row, col): rows are stored as consecutive word groups.
  function automatic int unsigned ctp_word_index(int unsigned row, int unsigned col,
                                                 int unsigned word_w, int unsigned words_per_row);
    return row * words_per_row + col / word_w;
  endfunction

  // Bit inside that word: the lowest column sits at the most significant bit.
  function automatic int unsigned ctp_bit_pos(int unsigned col, int unsigned word_w);
    return word_w - 1 - (col % word_w);
  endfunction

endpackage

// File: rtl/ctp_row_seq.sv
module ctp_row_seq #(
  parameter int unsigned ROWS = 12,
  localparam int unsigned RCW = $clog2(ROWS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  output logic           rd_en,
  output logic [RCW-1:0] issue_row,
  output logic           cap_en,
  output logic [RCW-1:0] cap_row,
  output logic           fetch_done
);

  logic           active_q;
  logic [RCW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == RCW'(ROWS)) active_q <= 1'b0;
      else                     cnt_q    <= cnt_q + 1'b1;
    end
  end

  // Cycle k issues row k and captures the word returned for row k-1.
  assign rd_en      = active_q && (cnt_q < RCW'(ROWS));
  assign issue_row  = cnt_q;
  assign cap_en     = active_q && (cnt_q != '0);
  assign cap_row    = cnt_q - 1'b1;
  assign fetch_done = active_q && (cnt_q == RCW'(ROWS));

endmodule

// File: rtl/ctp_gather.sv
module ctp_gather #(
  parameter int unsigned ROWS   = 12,
  parameter int unsigned WORD_W = 36,
  localparam int unsigned RCW = $clog2(ROWS + 1),
  localparam int unsigned BW  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [RCW-1:0]    cap_row,
  input  logic [BW-1:0]     bit_sel,
  input  logic [WORD_W-1:0] rd_data,
  output logic [ROWS-1:0]   code
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  bit_q <= 1'b0;
      else if (cap_en && (cap_row == RCW'(r)))     bit_q <= rd_data[bit_sel];
    end
    assign code[r] = bit_q;
  end

endmodule

// File: rtl/ctp_trim.sv
module ctp_trim #(
  parameter int unsigned COLS = 72,
  localparam int unsigned CIW = $clog2(COLS),
  localparam int unsigned LW  = $clog2(COLS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           accept,
  input  logic           nonblank,
  input  logic [CIW-1:0] col,
  output logic [LW-1:0]  len
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear)          len <= '0;
    else if (accept && nonblank)  len <= LW'(col) + 1'b1;
  end

endmodule

// File: rtl/ctp_transposer.sv
module ctp_transposer
  import ctp_pkg::*;
#(
  parameter int unsigned ROWS   = CTP_ROWS,
  parameter int unsigned COLS   = CTP_COLS,
  parameter int unsigned WORD_W = CTP_WORD_W,
  localparam int unsigned WPR   = COLS / WORD_W,
  localparam int unsigned WORDS = ROWS * WPR,
  localparam int unsigned AW    = $clog2(WORDS),
  localparam int unsigned CIW   = $clog2(COLS),
  localparam int unsigned LW    = $clog2(COLS + 1),
  localparam int unsigned RCW   = $clog2(ROWS + 1),
  localparam int unsigned BW    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic [ROWS-1:0]   col_code,
  output logic              col_valid,
  output logic              col_last,
  input  logic              col_ready,
  output logic              done,
  output logic [LW-1:0]     line_len
);

  ctp_state_e     state_q;
  logic [CIW-1:0] col_q;

  // Named internal events for the checker
  logic           line_start;
  logic           fetch_go;
  logic           fetch_done;
  logic           col_accept;
  logic           cap_en;
  logic [RCW-1:0] cap_row;
  logic [RCW-1:0] issue_row;
  logic [BW-1:0]  bit_sel;
  logic           at_last_col;

  assign at_last_col = (col_q == CIW'(COLS - 1));
  assign line_start  = (state_q == ST_IDLE) && start;
  assign col_valid   = (state_q == ST_PRESENT);
  assign col_last    = col_valid && at_last_col;
  assign col_accept  = col_valid && col_ready;
  assign fetch_go    = line_start || (col_accept && !at_last_col);
  assign done        = (state_q == ST_FINISH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_FETCH;
          col_q   <= '0;
        end
        ST_FETCH: if (fetch_done) state_q <= ST_PRESENT;
        ST_PRESENT: if (col_ready) begin
          if (at_last_col) state_q <= ST_FINISH;
          else begin
            state_q <= ST_FETCH;
            col_q   <= col_q + 1'b1;
          end
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  ctp_row_seq #(.ROWS(ROWS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (fetch_go),
    .rd_en      (rd_en),
    .issue_row  (issue_row),
    .cap_en     (cap_en),
    .cap_row    (cap_row),
    .fetch_done (fetch_done)
  );

  assign rd_addr = AW'(ctp_word_index(int'(issue_row), int'(col_q), WORD_W, WPR));
  assign bit_sel = BW'(ctp_bit_pos(int'(col_q), WORD_W));

  ctp_gather #(.ROWS(ROWS), .WORD_W(WORD_W)) u_gather (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .cap_row (cap_row),
    .bit_sel (bit_sel),
    .rd_data (rd_data),
    .code    (col_code)
  );

  ctp_trim #(.COLS(COLS)) u_trim (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (line_start),
    .accept   (col_accept),
    .nonblank (|col_code),
    .col      (col_q),
    .len      (line_len)
  );

endmodule

// File: rtl/ctp_transposer_chk.sv
module ctp_transposer_chk #(
  parameter int unsigned ROWS  = 12,
  parameter int unsigned COLS  = 72,
  parameter int unsigned WORDS = 24,
  parameter int unsigned AW    = 5,
  parameter int unsigned LW    = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_en,
  input logic [AW-1:0]   rd_addr,
  input logic [ROWS-1:0] col_code,
  input logic            col_valid,
  input logic            col_last,
  input logic            col_ready,
  input logic            col_accept,
  input logic            fetch_done,
  input logic            done,
  input logic [LW-1:0]   line_len
);

  a_r5_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_ready |=> col_valid && $stable(col_code) && $stable(col_last));

  a_r8_no_read_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> !rd_en);

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    col_accept && col_last |=> done);

  a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> line_len <= LW'(COLS));

  a_r4_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  a_r2_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr < AW'(WORDS));

  a_r2_present_after_gather: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> col_valid && !rd_en);

endmodule

bind ctp_transposer ctp_transposer_chk #(
  .ROWS(ROWS), .COLS(COLS), .WORDS(WORDS), .AW(AW), .LW(LW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .col_code   (col_code),
  .col_valid  (col_valid),
  .col_last   (col_last),
  .col_ready  (col_ready),
  .col_accept (col_accept),
  .fetch_done (fetch_done),
  .done       (done),
  .line_len   (line_len)
);

// File: tb/ctp_transposer_test.sv
module ctp_transposer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_en;
  logic [4:0]  rd_addr;
  logic [35:0] rd_data = '0;
  logic [11:0] col_code;
  logic        col_valid;
  logic        col_last;
  logic        col_ready = 1'b0;
  logic        done;
  logic [6:0]  line_len;

  always #4 clk = ~clk;

  ctp_transposer uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .col_code(col_code), .col_valid(col_valid), .col_last(col_last),
    .col_ready(col_ready), .done(done), .line_len(line_len)
  );

  logic [35:0] mem [24];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int  checks = 0;
  int  fails = 0;
  int  cycles = 0;
  int  exp_col = 0;
  int  read_n = 0;
  int  ready_mode = 0;
  bit  mon_on = 1'b0;
  bit  expect_done = 1'b0;
  bit  line_seen_done = 1'b0;
  bit  finished = 1'b0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference: column c, row r lives in half (c >= 36) of row pair r, MSB first.
  function automatic logic [11:0] ref_code(int c);
    logic [11:0] v;
    int half = (c >= 36) ? 1 : 0;
    int off  = c - 36 * half;
    for (int r = 0; r < 12; r++) v[r] = mem[2 * r + half][35 - off];
    return v;
  endfunction

  function automatic int ref_len();
    for (int c = 71; c >= 0; c--) if (ref_code(c) != 12'h0) return c + 1;
    return 0;
  endfunction

  function automatic void finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endfunction

  // Cycle-by-cycle comparison with the behavioural reference
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
    if (mon_on) begin
      case (ready_mode)
        0: col_ready = 1'b1;
        1: col_ready = 1'($urandom_range(0, 1));
        default: col_ready = ~col_ready;
      endcase
      if (expect_done) begin
        check(done == 1'b1, "R6", "done pulse", done, 1);
        check(int'(line_len) == ref_len(), "R6", "line_len", line_len, ref_len());
        check(exp_col == 72, "R4", "columns presented", exp_col, 72);
        expect_done = 1'b0;
        line_seen_done = 1'b1;
      end else if (done) begin
        check(1'b0, "R6", "unexpected done", done, 0);
      end
      if (rd_en) begin
        check(read_n < 12 && exp_col < 72, "R2", "read count", read_n, 11);
        check(int'(rd_addr) == read_n * 2 + ((exp_col >= 36) ? 1 : 0), "R2", "rd_addr",
              rd_addr, read_n * 2 + ((exp_col >= 36) ? 1 : 0));
        check(!col_valid, "R8", "read while waiting", col_valid, 0);
        read_n++;
      end
      if (col_valid) begin
        check(read_n == 12, "R2", "reads before column", read_n, 12);
        check(col_code == ref_code(exp_col), "R3", "col_code", col_code, ref_code(exp_col));
        check(col_last == (exp_col == 71), "R4", "col_last", col_last, exp_col == 71);
        if (col_ready) begin
          if (exp_col == 71) expect_done = 1'b1;
          exp_col++;
          read_n = 0;
        end
      end else begin
        check(!col_last, "R4", "col_last without valid", col_last, 0);
      end
    end
  end

  task automatic run_line(int mode, bit busy_start);
    ready_mode = mode;
    exp_col = 0;
    read_n = 0;
    line_seen_done = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (busy_start) begin
      // R7: extra starts in mid-line must leave the run unchanged
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (400) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int n = 0; n < 5000 && !line_seen_done; n++) @(negedge clk);
    check(line_seen_done, "R6", "line completion", line_seen_done, 1);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      check(!rd_en && !col_valid, "R7", "idle after done", {rd_en, col_valid}, 0);
    end
  endtask

  task automatic clear_mem();
    for (int w = 0; w < 24; w++) mem[w] = '0;
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    check(!col_valid && !col_last && !rd_en && !done, "R1", "outputs in reset",
          {col_valid, col_last, rd_en, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!col_valid && !col_last && !rd_en && !done, "R1", "outputs after reset",
          {col_valid, col_last, rd_en, done}, 0);
    check(line_len == 7'd0, "R1", "line_len after reset", line_len, 0);
    mon_on = 1'b1;

    run_line(0, 1'b0);                       // all blank: length 0

    clear_mem(); mem[0][35] = 1'b1;          // column 0, row 0
    run_line(0, 1'b0);

    clear_mem(); mem[23][0] = 1'b1;          // column 71, row 11
    run_line(2, 1'b0);

    clear_mem(); mem[10][0] = 1'b1; mem[13][35] = 1'b1;  // columns 35 and 36
    run_line(1, 1'b0);

    clear_mem();                             // diagonal: column r carries row r only
    for (int r = 0; r < 12; r++) mem[2 * r][35 - r] = 1'b1;
    run_line(2, 1'b0);

    for (int w = 0; w < 24; w++) mem[w] = {$urandom(), $urandom()} & 36'hF_FFFF_FFFF;
    run_line(1, 1'b1);

    for (int w = 0; w < 24; w++) begin       // trailing blanks after column 40
      mem[w] = {$urandom(), $urandom()} & 36'hF_FFFF_FFFF;
      if (w % 2 == 1) mem[w] = mem[w] & 36'hF_8000_0000;
    end
    run_line(1, 1'b1);

    mon_on = 1'b0;
    finish_run();
  end

endmodule